// File: doc/BRIEF.md
# Sequenced ADC Frame Reader

This block is the host side of a 16-bit serial link to an eight-channel successive-approximation converter. On each accepted request it lowers chip select, clocks out one control word on the data-in line and reads one result word from the data-out line. The control word carries a write flag, a repeat flag, a channel-select mask and a power-down flag. Each frame is followed by an enforced idle gap. After reset, no frame starts until a start-up delay has run out.

The converter returns each result one frame after the conversion that produced it. The word it returns during a configuring write, and during the frame after that write, holds nothing usable. The reader therefore does not trust the order in which it issued frames. It takes the 4-bit channel tag at the head of each returned word and uses it to pick a slot in a per-channel result table, each slot with its own valid flag. Frames that cannot carry a real sample are dropped: the configuring frame, the frame after it, the first frame after reset, an all-ones word, and a tag beyond the table.

The SCLK half-period, the quiet gap and the start-up delay are parameters counted in system clock cycles. A busy/done pair tells the requester when the next frame can be accepted.

Top module: `seq_adc_reader`

## Requirements
- R1: While rst_ni is low: cs_n_o=1, sclk_o=1, busy_o=1, done_o=0, and every res_valid_o bit is 0.
- R2: After reset is released, busy_o stays high and start_i is ignored for STARTUP_CYC clock cycles. The first fall of cs_n_o comes no earlier than STARTUP_CYC cycles after release.
- R3: Each frame holds cs_n_o low for exactly 16 falling edges of sclk_o. sclk_o is high whenever cs_n_o is high.
- R4: The control word goes out MSB first and is stable on din_o at every falling sclk_o edge. Bit 15 is the write flag, bit 14 the repeat flag, bit 13-i is mask bit i (channel 0 at bit 13), and bit 0 is power-down. All other bits are 0.
- R5: Between the rise of cs_n_o that ends a frame and the next fall, cs_n_o stays high for at least QUIET_CYC clock cycles.
- R6: Every low phase of sclk_o lasts exactly CLK_DIV clock cycles.
- R7: The master samples data-out just before each falling sclk_o edge, so the first sample is the bit present when CS falls. In the returned word, bits 15:12 are the channel tag and bits 11:2 are the 10-bit result; bits 1:0 are ignored. An accepted word sets the valid flag of slot tag and writes the result into that slot, one cycle after done_o.
- R8: The word returned in a frame with the write flag set is not stored. Neither is the word of the frame right after such a frame, nor the word of the first frame after reset.
- R9: A word whose bits 15:2 are all ones is not stored.
- R10: A word whose tag is N_CH or above is not stored.
- R11: done_o is a one-cycle pulse in the cycle cs_n_o rises, and busy_o is high throughout a frame. A start_i pulse while busy_o is high is ignored: it changes neither the frame in progress nor the number of frames.
- R12: A stored word changes only its own slot. Every other slot keeps its data and its valid flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request one frame when not busy |
| wr_i | input | 1 | Write flag of the requested control word |
| rep_i | input | 1 | Repeat flag of the requested control word |
| mask_i | input | N_CH | Channel-select mask |
| pd_i | input | 1 | Power-down flag |
| cs_n_o | output | 1 | Chip select, active low |
| sclk_o | output | 1 | Serial clock, idles high |
| din_o | output | 1 | Serial control data to the converter |
| dout_i | input | 1 | Serial result data from the converter |
| busy_o | output | 1 | Start-up wait, frame or quiet gap in progress |
| done_o | output | 1 | One-cycle pulse at the end of a frame |
| res_data_o | output | N_CH*10 | Result table, slot i at bits i*10 +: 10 |
| res_valid_o | output | N_CH | Per-slot valid flags |

## Verification
The assertions take some things for granted about the inputs. rst_ni is released synchronously. The timing parameters are at least 1. N_CH is no more than 8, so every mask bit has a place in the control word. The converter peer updates data-out only after a falling sclk_o edge. The bench stimulus stays within these bounds. Its converter peer shifts on the falling edges the block produces and loads its first bit when chip select falls. The bench raises start_i only on falling clock edges, and only while busy_o is low, except in the one test that probes the ignore rule. The random words, tags and masks it sends stay inside the 16-bit frame format.

// File: rtl/seq_adc_pkg.sv
package seq_adc_pkg;
  localparam int FRAME_W = 16;
  localparam int TAG_W   = 4;
  localparam int RES_W   = 10;
  localparam int WORD_W  = TAG_W + RES_W;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_QUIET = 2'd2
  } frame_st_e;
endpackage

// File: rtl/adc_boot_timer.sv
module adc_boot_timer #(
  parameter int STARTUP_CYC = 50000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic ready_o
);
  localparam int CW = $clog2(STARTUP_CYC + 1);
  localparam logic [CW-1:0] CNT_END = CW'(STARTUP_CYC);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (cnt_q != CNT_END) cnt_q <= cnt_q + 1'b1;
  end

  assign ready_o = (cnt_q == CNT_END);
endmodule

// File: rtl/adc_frame_engine.sv
module adc_frame_engine
  import seq_adc_pkg::*;
#(
  parameter int CLK_DIV   = 3,
  parameter int QUIET_CYC = 5,
  parameter int N_CH      = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ready_i,
  input  logic              start_i,
  input  logic              wr_i,
  input  logic              rep_i,
  input  logic [N_CH-1:0]   mask_i,
  input  logic              pd_i,
  input  logic              dout_i,
  output logic              cs_n_o,
  output logic              sclk_o,
  output logic              din_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              word_vld_o,
  output logic              word_wr_o,
  output logic [WORD_W-1:0] word_o
);
  localparam int DW = $clog2(CLK_DIV + 1);
  localparam int QW = $clog2(QUIET_CYC + 1);
  localparam logic [DW-1:0] DIV_LAST   = DW'(CLK_DIV - 1);
  localparam logic [QW-1:0] QUIET_LAST = QW'(QUIET_CYC - 1);

  frame_st_e          st_q;
  logic [DW-1:0]      div_q;
  logic [QW-1:0]      quiet_q;
  logic [3:0]         bit_q;
  logic [FRAME_W-1:0] tx_q, rx_q, ctrl_w;

  always_comb begin
    ctrl_w     = '0;
    ctrl_w[15] = wr_i;
    ctrl_w[14] = rep_i;
    for (int i = 0; i < N_CH; i++) ctrl_w[13-i] = mask_i[i];
    ctrl_w[0]  = pd_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      div_q      <= '0;
      quiet_q    <= '0;
      bit_q      <= '0;
      tx_q       <= '0;
      rx_q       <= '0;
      cs_n_o     <= 1'b1;
      sclk_o     <= 1'b1;
      done_o     <= 1'b0;
      word_vld_o <= 1'b0;
      word_wr_o  <= 1'b0;
    end else begin
      done_o     <= 1'b0;
      word_vld_o <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start_i && ready_i) begin
          st_q      <= ST_SHIFT;
          cs_n_o    <= 1'b0;
          sclk_o    <= 1'b1;
          tx_q      <= ctrl_w;
          word_wr_o <= wr_i;
          div_q     <= '0;
          bit_q     <= '0;
        end
        ST_SHIFT: begin
          if (div_q != DIV_LAST) begin
            div_q <= div_q + 1'b1;
          end else begin
            div_q <= '0;
            if (sclk_o) begin
              // data-out still holds the bit for this edge
              sclk_o <= 1'b0;
              rx_q   <= {rx_q[FRAME_W-2:0], dout_i};
            end else begin
              sclk_o <= 1'b1;
              if (bit_q == 4'd15) begin
                st_q       <= ST_QUIET;
                cs_n_o     <= 1'b1;
                quiet_q    <= '0;
                done_o     <= 1'b1;
                word_vld_o <= 1'b1;
              end else begin
                bit_q <= bit_q + 1'b1;
                tx_q  <= {tx_q[FRAME_W-2:0], 1'b0};
              end
            end
          end
        end
        ST_QUIET: begin
          if (quiet_q == QUIET_LAST) st_q <= ST_IDLE;
          else                       quiet_q <= quiet_q + 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign din_o  = tx_q[FRAME_W-1];
  assign word_o = rx_q[FRAME_W-1:FRAME_W-WORD_W];
  assign busy_o = !ready_i || (st_q != ST_IDLE);
endmodule

// File: rtl/adc_result_table.sv
module adc_result_table
  import seq_adc_pkg::*;
#(
  parameter int N_CH = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  word_vld_i,
  input  logic                  word_wr_i,
  input  logic [WORD_W-1:0]     word_i,
  output logic [N_CH*RES_W-1:0] data_o,
  output logic [N_CH-1:0]       valid_o
);
  logic             prev_wr_q;
  logic [TAG_W-1:0] tag;
  logic             keep;

  assign tag  = word_i[WORD_W-1 -: TAG_W];
  assign keep = word_vld_i && !word_wr_i && !prev_wr_q &&
                (word_i != '1) && ({1'b0, tag} < (TAG_W+1)'(N_CH));

  // reset counts as a preceding write: the first frame is never trusted
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         prev_wr_q <= 1'b1;
    else if (word_vld_i) prev_wr_q <= word_wr_i;
  end

  for (genvar g = 0; g < N_CH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        data_o[g*RES_W +: RES_W] <= '0;
        valid_o[g]               <= 1'b0;
      end else if (keep && tag == TAG_W'(g)) begin
        data_o[g*RES_W +: RES_W] <= word_i[RES_W-1:0];
        valid_o[g]               <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/seq_adc_reader.sv
module seq_adc_reader
  import seq_adc_pkg::*;
#(
  parameter int CLK_DIV     = 3,
  parameter int QUIET_CYC   = 5,
  parameter int STARTUP_CYC = 50000,
  parameter int N_CH        = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic                  wr_i,
  input  logic                  rep_i,
  input  logic [N_CH-1:0]       mask_i,
  input  logic                  pd_i,
  output logic                  cs_n_o,
  output logic                  sclk_o,
  output logic                  din_o,
  input  logic                  dout_i,
  output logic                  busy_o,
  output logic                  done_o,
  output logic [N_CH*RES_W-1:0] res_data_o,
  output logic [N_CH-1:0]       res_valid_o
);
  logic              ready;
  logic              word_vld, word_wr;
  logic [WORD_W-1:0] word;

  adc_boot_timer #(.STARTUP_CYC(STARTUP_CYC)) u_boot (
    .clk_i(clk_i), .rst_ni(rst_ni), .ready_o(ready)
  );

  adc_frame_engine #(.CLK_DIV(CLK_DIV), .QUIET_CYC(QUIET_CYC), .N_CH(N_CH)) u_eng (
    .clk_i(clk_i), .rst_ni(rst_ni), .ready_i(ready), .start_i(start_i),
    .wr_i(wr_i), .rep_i(rep_i), .mask_i(mask_i), .pd_i(pd_i), .dout_i(dout_i),
    .cs_n_o(cs_n_o), .sclk_o(sclk_o), .din_o(din_o), .busy_o(busy_o),
    .done_o(done_o), .word_vld_o(word_vld), .word_wr_o(word_wr), .word_o(word)
  );

  adc_result_table #(.N_CH(N_CH)) u_tab (
    .clk_i(clk_i), .rst_ni(rst_ni), .word_vld_i(word_vld), .word_wr_i(word_wr),
    .word_i(word), .data_o(res_data_o), .valid_o(res_valid_o)
  );
endmodule

// File: rtl/seq_adc_reader_chk.sv
module seq_adc_reader_chk #(
  parameter int QUIET_CYC   = 5,
  parameter int STARTUP_CYC = 50000,
  parameter int N_CH        = 8,
  parameter int RES_W       = 10
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  cs_n_o,
  input logic                  sclk_o,
  input logic                  busy_o,
  input logic                  done_o,
  input logic [N_CH*RES_W-1:0] res_data_o,
  input logic [N_CH-1:0]       res_valid_o
);
  localparam int QW = $clog2(QUIET_CYC + 1);
  localparam int BW = $clog2(STARTUP_CYC + 1);
  localparam logic [QW-1:0] QMAX = QW'(QUIET_CYC);
  localparam logic [BW-1:0] BMAX = BW'(STARTUP_CYC);

  logic [QW-1:0] hi_cnt;
  logic [BW-1:0] boot_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          hi_cnt <= '0;
    else if (!cs_n_o)     hi_cnt <= '0;
    else if (hi_cnt != QMAX) hi_cnt <= hi_cnt + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               boot_cnt <= '0;
    else if (boot_cnt != BMAX) boot_cnt <= boot_cnt + 1'b1;
  end

  AST_SCLK_IDLE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_o |-> sclk_o); // R3
  AST_BOOT_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_n_o) |-> boot_cnt == BMAX); // R2
  AST_QUIET_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_n_o) |-> hi_cnt == QMAX); // R5
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R11
  AST_DONE_AT_CS_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_n_o) |-> done_o); // R11
  AST_BUSY_IN_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_n_o |-> busy_o); // R11
  AST_VALID_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(res_valid_o) & ~res_valid_o) == '0); // R7
  AST_TABLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(done_o) |-> ($stable(res_data_o) && $stable(res_valid_o))); // R12
endmodule

bind seq_adc_reader seq_adc_reader_chk #(
  .QUIET_CYC(QUIET_CYC), .STARTUP_CYC(STARTUP_CYC), .N_CH(N_CH), .RES_W(10)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cs_n_o(cs_n_o), .sclk_o(sclk_o),
  .busy_o(busy_o), .done_o(done_o), .res_data_o(res_data_o),
  .res_valid_o(res_valid_o)
);

// File: tb/sim_seq_adc_reader.sv
module sim_seq_adc_reader;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_DIV    = 3;
  localparam int QUIET      = 5;
  localparam int STARTUP    = 40;
  localparam int N_CH       = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, wr = 1'b0, rep = 1'b0, pd = 1'b0;
  logic [N_CH-1:0] mask = '0;
  logic cs_n, sclk, din, busy, done;
  logic dout = 1'b1;
  logic [N_CH*10-1:0] res_data;
  logic [N_CH-1:0]    res_valid;

  int n_tests = 0, n_fail = 0;

  // converter peer
  logic [15:0] tx_word = 16'hFFFF, sh_out = 16'hFFFF, rx_word = '0;
  int edges = 0;
  // monitors
  int low_len = 0, len_err = 0, hi_len = 0, quiet_err = 0, frames = 0;
  // reference table
  logic [9:0] m_data [N_CH];
  logic       m_valid [N_CH];
  logic       m_prev_wr = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;

  seq_adc_reader #(.CLK_DIV(CLK_DIV), .QUIET_CYC(QUIET), .STARTUP_CYC(STARTUP), .N_CH(N_CH)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .wr_i(wr), .rep_i(rep),
    .mask_i(mask), .pd_i(pd), .cs_n_o(cs_n), .sclk_o(sclk), .din_o(din),
    .dout_i(dout), .busy_o(busy), .done_o(done), .res_data_o(res_data),
    .res_valid_o(res_valid)
  );

  always @(negedge cs_n) begin
    sh_out = tx_word;
    dout   = sh_out[15];
    edges  = 0;
    frames = frames + 1;
  end

  always @(negedge sclk) begin
    if (!cs_n) begin
      rx_word = {rx_word[14:0], din};
      edges   = edges + 1;
      sh_out  = {sh_out[14:0], 1'b1};
      dout    = sh_out[15];
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (!sclk) low_len = low_len + 1;
      else if (low_len != 0) begin
        if (low_len != CLK_DIV) len_err = len_err + 1;
        low_len = 0;
      end
      if (cs_n) hi_len = hi_len + 1;
      else begin
        if (hi_len != 0 && frames > 1 && hi_len < QUIET) quiet_err = quiet_err + 1;
        hi_len = 0;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_ctrl(input logic w, input logic r,
                                           input logic [N_CH-1:0] m, input logic p);
    logic [15:0] c;
    c = {w, r, 14'd0};
    for (int i = 0; i < N_CH; i++) c[13-i] = m[i];
    c[0] = p;
    return c;
  endfunction

  task automatic finish_frame(input logic [15:0] ectl, input logic fwr);
    logic [3:0] tag;
    string      cat;
    bit         keep;
    while (!done) @(negedge clk);
    chk(edges == 16, "R3", "falling sclk edges", edges, 16);
    chk(rx_word == ectl, "R4", "control word", rx_word, ectl);
    chk(len_err == 0, "R6", "sclk low phases off", len_err, 0);
    chk(quiet_err == 0, "R5", "short quiet gaps", quiet_err, 0);
    @(negedge clk);
    chk(!done, "R11", "done width", done, 0);
    tag  = tx_word[15:12];
    keep = 1'b1;
    cat  = "R7";
    if (fwr || m_prev_wr) begin keep = 1'b0; cat = "R8"; end
    else if (tx_word[15:2] == 14'h3FFF) begin keep = 1'b0; cat = "R9"; end
    else if (tag >= N_CH) begin keep = 1'b0; cat = "R10"; end
    m_prev_wr = fwr;
    if (keep) begin
      m_data[tag]  = tx_word[11:2];
      m_valid[tag] = 1'b1;
    end
    @(negedge clk);
    if (tag < N_CH) begin
      chk(res_valid[tag] == m_valid[tag] && res_data[tag*10 +: 10] == m_data[tag],
          cat, "target slot", {res_valid[tag], res_data[tag*10 +: 10]},
          {m_valid[tag], m_data[tag]});
    end
    for (int i = 0; i < N_CH; i++) begin
      if (res_valid[i] != m_valid[i] || res_data[i*10 +: 10] != m_data[i]) begin
        chk(1'b0, "R12", $sformatf("slot %0d", i), {res_valid[i], res_data[i*10 +: 10]},
            {m_valid[i], m_data[i]});
        break;
      end
      if (i == N_CH-1) chk(1'b1, "R12", "all slots", 0, 0);
    end
    len_err = 0;
    quiet_err = 0;
  endtask

  task automatic do_frame(input logic w, input logic r, input logic [N_CH-1:0] m,
                          input logic p, input logic [15:0] word, input bit poke);
    int fr;
    while (busy) @(negedge clk);
    tx_word = word;
    wr = w; rep = r; mask = m; pd = p;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (20) @(negedge clk);
      wr = ~w; mask = ~m; pd = ~p; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    fr = frames;
    finish_frame(exp_ctrl(w, r, m, p), w);
    if (poke) begin
      repeat (QUIET + 4) @(negedge clk);
      chk(frames == fr && cs_n, "R11", "frames after start while busy", frames, fr);
    end
  endtask

  function automatic logic [15:0] mk_word(input int t, input int d);
    return {4'(t), 10'(d), 2'b01};
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int wait_cyc;
    void'($urandom(32'd7341));
    for (int i = 0; i < N_CH; i++) begin m_data[i] = '0; m_valid[i] = 1'b0; end
    // R1 reset state
    #(CLK_PERIOD * 3 + 1);
    chk(cs_n && sclk && busy && !done && res_valid == '0, "R1", "reset outputs",
        {cs_n, sclk, busy, done, res_valid}, {4'b1110, 8'h00});
    // R2: request held from release; the first frame (write) must wait
    wr = 1'b1; rep = 1'b0; mask = 8'h0F; pd = 1'b0; start = 1'b1;
    tx_word = mk_word(3, 10'h155);
    @(negedge clk);
    rst_n = 1'b1;
    wait_cyc = 0;
    while (cs_n && wait_cyc < 1000) begin
      @(negedge clk);
      if (cs_n) wait_cyc++;
      if (wait_cyc == STARTUP - 1) chk(busy, "R2", "busy during start-up", busy, 1);
    end
    start = 1'b0;
    chk(wait_cyc >= STARTUP && wait_cyc <= STARTUP + 2, "R2", "cycles before first CS fall",
        wait_cyc, STARTUP);
    finish_frame(exp_ctrl(1'b1, 1'b0, 8'h0F, 1'b0), 1'b1);
    // R8: frame after the write is dropped, then a good one lands (R7)
    do_frame(1'b0, 1'b0, 8'h00, 1'b0, mk_word(3, 10'h2AA), 1'b0);
    do_frame(1'b0, 1'b0, 8'h00, 1'b0, mk_word(3, 10'h2AB), 1'b0);
    do_frame(1'b0, 1'b1, 8'h00, 1'b0, mk_word(0, 10'h3FF), 1'b0);
    do_frame(1'b0, 1'b1, 8'h00, 1'b0, mk_word(7, 10'h001), 1'b0);
    // R9 all ones, R10 out-of-range tag
    do_frame(1'b0, 1'b0, 8'h00, 1'b0, 16'hFFFF, 1'b0);
    do_frame(1'b0, 1'b0, 8'h00, 1'b0, mk_word(9, 10'h123), 1'b0);
    do_frame(1'b0, 1'b0, 8'h00, 1'b0, mk_word(15, 10'h0F0), 1'b0);
    // R4 field positions: single channel 0, channel 7, power-down
    do_frame(1'b1, 1'b1, 8'h01, 1'b1, mk_word(1, 10'h011), 1'b0);
    do_frame(1'b0, 1'b0, 8'h80, 1'b0, mk_word(2, 10'h022), 1'b0);
    do_frame(1'b0, 1'b0, 8'h00, 1'b0, mk_word(2, 10'h033), 1'b0);
    // R11: start while busy is ignored
    do_frame(1'b0, 1'b1, 8'h5A, 1'b0, mk_word(4, 10'h0C3), 1'b1);
    // random frames
    for (int k = 0; k < 40; k++) begin
      logic [15:0] w16;
      int sel;
      sel = $urandom_range(0, 7);
      if (sel == 0)      w16 = 16'hFFFF;
      else if (sel == 1) w16 = mk_word($urandom_range(8, 15), $urandom_range(0, 1023));
      else               w16 = mk_word($urandom_range(0, 7), $urandom_range(0, 1023));
      w16[1:0] = 2'($urandom_range(0, 3));
      if (sel == 0) w16 = 16'hFFFF;
      do_frame(($urandom_range(0, 3) == 0), 1'($urandom_range(0, 1)),
               8'($urandom_range(0, 255)), 1'($urandom_range(0, 1)), w16, 1'b0);
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule